// File: doc/BRIEF.md
# Parallel Port Direction and Tristate Control

This block sits next to a 24-line parallel port that runs only in its basic latched mode. The lines form two 8-bit ports (A and B) and a third port C that is split into two 4-bit halves. A small bus writes four byte registers: three port data registers and one shared control register. From the control byte the block keeps one direction bit for each of the four port groups, plus one global bit that turns all transceivers off. From this stored state it drives the direction and output-enable controls of the external bidirectional transceivers.

The most significant control bit does two jobs. A control write with that bit set loads a new set of group directions and also puts every transceiver into tristate. A later control write with that bit clear only enables the transceivers again and leaves the directions unchanged. Software can therefore set the directions, preset the output data while nothing is driven, and then release the pins with known values on them. Port reads return the live pin level for groups set as input, and the output latch for groups set as output.

Top module: `pio_dir_ctrl`

## Requirements
- R1: After reset, all four groups are inputs (`xcvr_dir` = 0), the transceivers are enabled (`xcvr_oe_n` = 0), no line is driven (`pin_oe` = 0) and the output latches are zero.
- R2: A control write (offset 3) with bit 7 = 1 and bits 6, 5, 2 all 0 loads the group directions from the following bits, where 1 means input: port A from bit 4, port B from bit 1, upper half of C from bit 3, lower half of C from bit 0. The change shows on `xcvr_dir` after the write's clock edge.
- R3: Every control write stores bit 7 as the global disable. While it is 1, `xcvr_oe_n` = 1 and no line is driven.
- R4: A control write with bit 7 = 0 leaves the stored directions unchanged.
- R5: A control write with bit 7 = 1 and any of bits 6, 5 or 2 set leaves the stored directions unchanged, but still stores bit 7.
- R6: A write to offset 0, 1 or 2 updates the output latch of port A, B or C (pins 7:0, 15:8, 23:16). `pin_out` shows the new value after the clock edge, whatever the group's direction.
- R7: A line is driven (`pin_oe` = 1) only when its group is set as output and the global disable is 0. `xcvr_dir[g]` is 1 exactly when group g is set as output, with g = 0 A, 1 B, 2 lower C, 3 upper C.
- R8: A read of offset 0, 1 or 2 returns, in the same cycle, `pin_in` for the bits of groups set as input and the output latch for the bits of groups set as output.
- R9: A read of offset 3 returns the control state as {disable, 0, 0, dirA, dirChi, 0, dirB, dirClo}.
- R10: The sequence "control with bit 7 = 1, data writes, control with bit 7 = 0 and the same direction bits" ends with the preset data driven on every output line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 2 | Register offset: 0 A, 1 B, 2 C, 3 control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pin_in | input | 24 | Live level of the port lines |
| pin_out | output | 24 | Output latch values for the port lines |
| pin_oe | output | 24 | Per-line drive enable |
| xcvr_dir | output | 4 | Per-group transceiver direction, 1 = toward pins |
| xcvr_oe_n | output | 1 | Global transceiver enable, active low |

## Verification
The checker monitors on every cycle the rules that do not depend on sequence: a tristated port drives nothing, a group drives its lines only when set as output, directions change only on a valid configuring write, and each control write stores bit 7. Other behaviour can only be shown through the bench's scenarios. This includes the exact bit mapping from the control byte to each group, the mixed per-bit read of port C when its halves point in opposite directions, the control byte read back, and the full preset-then-release sequence.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned NGRP     = 4;
  localparam int unsigned NPORT    = 3;
  localparam int unsigned PINS     = NPORT * BYTE_W;
  localparam int unsigned ADDR_W   = 2;
  localparam int unsigned CTRL_OFS = 3;
  localparam int unsigned TRI_BIT  = 7;

  typedef enum logic [1:0] {
    GRP_A   = 2'd0,
    GRP_B   = 2'd1,
    GRP_CLO = 2'd2,
    GRP_CHI = 2'd3
  } grp_e;

  // Lowest pin index of a group.
  function automatic int unsigned grp_lsb(input int unsigned g);
    case (g)
      0: grp_lsb = 0;
      1: grp_lsb = 8;
      2: grp_lsb = 16;
      default: grp_lsb = 20;
    endcase
  endfunction

  function automatic int unsigned grp_width(input int unsigned g);
    grp_width = (g < 2) ? BYTE_W : BYTE_W / 2;
  endfunction

  // Register offset holding the group's data.
  function automatic int unsigned grp_port(input int unsigned g);
    grp_port = (g < 2) ? g : 2;
  endfunction

  // Control byte bit holding the group's direction (1 = input).
  function automatic int unsigned grp_dir_bit(input int unsigned g);
    case (g)
      0: grp_dir_bit = 4;
      1: grp_dir_bit = 1;
      2: grp_dir_bit = 0;
      default: grp_dir_bit = 3;
    endcase
  endfunction

  // Only the basic latched mode is accepted: mode bits must be zero.
  function automatic logic ctrl_mode_ok(input logic [BYTE_W-1:0] d);
    ctrl_mode_ok = (d[6:5] == 2'b00) && !d[2];
  endfunction

  // Rebuild the control byte from stored state.
  function automatic logic [BYTE_W-1:0] pack_ctrl(input logic tri_q,
                                                  input logic [NGRP-1:0] dir_in);
    logic [BYTE_W-1:0] r;
    r = '0;
    r[TRI_BIT] = tri_q;
    for (int g = 0; g < NGRP; g++) r[grp_dir_bit(g)] = dir_in[g];
    pack_ctrl = r;
  endfunction
endpackage

// File: rtl/pio_ctrl_reg.sv
module pio_ctrl_reg
  import pio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [BYTE_W-1:0] wdata,
  output logic [NGRP-1:0]   dir_in,
  output logic              tri_q,
  output logic              cfg_load,
  output logic              cfg_reject
);
  logic cfg_req;

  always_comb begin
    cfg_req    = wr_stb && wdata[TRI_BIT];
    cfg_load   = cfg_req && ctrl_mode_ok(wdata);
    cfg_reject = cfg_req && !ctrl_mode_ok(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_in <= '1;
      tri_q  <= 1'b0;
    end else begin
      if (wr_stb) tri_q <= wdata[TRI_BIT];
      if (cfg_load) begin
        for (int g = 0; g < NGRP; g++) dir_in[g] <= wdata[grp_dir_bit(g)];
      end
    end
  end
endmodule

// File: rtl/pio_grp.sv
module pio_grp #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_stb,
  input  logic [W-1:0] wdata,
  input  logic         is_input,
  input  logic         tri_q,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] rd_bits,
  output logic         drive_out
);
  logic [W-1:0] lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lat_q <= '0;
    else if (wr_stb) lat_q <= wdata;
  end

  always_comb begin
    drive_out = !is_input;
    pin_out   = lat_q;
    pin_oe    = {W{drive_out && !tri_q}};
    rd_bits   = is_input ? pin_in : lat_q;
  end
endmodule

// File: rtl/pio_dir_ctrl.sv
module pio_dir_ctrl
  import pio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe,
  output logic [NGRP-1:0]   xcvr_dir,
  output logic              xcvr_oe_n
);
  logic [NGRP-1:0] dir_in;
  logic            tri_q;
  logic            cfg_load;
  logic            cfg_reject;
  logic            ctrl_wr;
  logic [PINS-1:0] port_rd;

  assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(CTRL_OFS));

  pio_ctrl_reg u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_stb     (ctrl_wr),
    .wdata      (bus_wdata),
    .dir_in     (dir_in),
    .tri_q      (tri_q),
    .cfg_load   (cfg_load),
    .cfg_reject (cfg_reject)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int unsigned LSB  = grp_lsb(g);
    localparam int unsigned W    = grp_width(g);
    localparam int unsigned PORT = grp_port(g);
    localparam int unsigned BOFS = LSB - PORT * BYTE_W;
    logic grp_wr;
    assign grp_wr = bus_wr && (bus_addr == ADDR_W'(PORT));

    pio_grp #(.W(W)) u_grp (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_stb    (grp_wr),
      .wdata     (bus_wdata[BOFS +: W]),
      .is_input  (dir_in[g]),
      .tri_q     (tri_q),
      .pin_in    (pin_in[LSB +: W]),
      .pin_out   (pin_out[LSB +: W]),
      .pin_oe    (pin_oe[LSB +: W]),
      .rd_bits   (port_rd[LSB +: W]),
      .drive_out (xcvr_dir[g])
    );
  end

  assign xcvr_oe_n = tri_q;

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = port_rd[0*BYTE_W +: BYTE_W];
      2'd1:    bus_rdata = port_rd[1*BYTE_W +: BYTE_W];
      2'd2:    bus_rdata = port_rd[2*BYTE_W +: BYTE_W];
      default: bus_rdata = pack_ctrl(tri_q, dir_in);
    endcase
  end
endmodule

// File: rtl/pio_dir_ctrl_chk.sv
module pio_dir_ctrl_chk
  import pio_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BYTE_W-1:0] bus_wdata,
  input logic [PINS-1:0]   pin_out,
  input logic [PINS-1:0]   pin_oe,
  input logic [NGRP-1:0]   xcvr_dir,
  input logic              xcvr_oe_n,
  input logic              cfg_load,
  input logic              cfg_reject
);
  logic ctrl_w;
  assign ctrl_w = bus_wr && (bus_addr == 2'd3);

  a_r1_reset_state: assert property (@(posedge clk)
    $rose(rst_n) |-> (xcvr_dir == '0) && !xcvr_oe_n && (pin_oe == '0) && (pin_out == '0));

  a_r2_dirs_only_on_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> $stable(xcvr_dir));

  a_r3_tri_captured: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_w |=> (xcvr_oe_n == $past(bus_wdata[7])));

  a_r3_tri_blocks_drive: assert property (@(posedge clk) disable iff (!rst_n)
    xcvr_oe_n |-> (pin_oe == '0));

  a_r4_clear_keeps_dirs: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_w && !bus_wdata[7]) |=> $stable(xcvr_dir));

  a_r5_bad_mode_keeps_dirs: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_reject |=> $stable(xcvr_dir));

  a_r6_port_a_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0) |=> (pin_out[7:0] == $past(bus_wdata)));

  a_r7_a_drive_needs_out: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe[7:0] != '0) |-> xcvr_dir[0]);

  a_r7_chi_drive_needs_out: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe[23:20] != '0) |-> xcvr_dir[3]);
endmodule

bind pio_dir_ctrl pio_dir_ctrl_chk u_chk (.*);

// File: tb/pio_dir_ctrl_bench.sv
module pio_dir_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [7:0]  bus_wdata = 8'd0;
  logic [7:0]  bus_rdata;
  logic [23:0] pin_in = 24'd0;
  logic [23:0] pin_out;
  logic [23:0] pin_oe;
  logic [3:0]  xcvr_dir;
  logic        xcvr_oe_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Model state: d_* = 1 means input.
  logic d_a = 1, d_b = 1, d_cl = 1, d_ch = 1;
  logic m_tri = 0;
  logic [23:0] m_lat = '0;

  always #4 clk = ~clk;

  pio_dir_ctrl u_pio_dir_ctrl (.*);

  function automatic logic line_in(input int i);
    if (i < 8) return d_a;
    if (i < 16) return d_b;
    if (i < 20) return d_cl;
    return d_ch;
  endfunction

  function automatic logic [23:0] exp_oe();
    logic [23:0] r;
    for (int i = 0; i < 24; i++) r[i] = !line_in(i) && !m_tri;
    return r;
  endfunction

  function automatic logic [3:0] exp_xd();
    return {!d_ch, !d_cl, !d_b, !d_a};
  endfunction

  function automatic logic [7:0] exp_rd(input logic [1:0] a, input logic [23:0] pins);
    logic [7:0] r;
    if (a == 2'd3) return {m_tri, 2'b00, d_a, d_ch, 1'b0, d_b, d_cl};
    for (int k = 0; k < 8; k++)
      r[k] = line_in(a*8 + k) ? pins[a*8 + k] : m_lat[a*8 + k];
    return r;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_outs(input string req);
    chk(req, "pin_out", 32'(pin_out), 32'(m_lat));
    chk("R7", "pin_oe", 32'(pin_oe), 32'(exp_oe()));
    chk("R7", "xcvr_dir", 32'(xcvr_dir), 32'(exp_xd()));
    chk("R3", "xcvr_oe_n", 32'(xcvr_oe_n), 32'(m_tri));
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    if (a == 2'd3) begin
      m_tri = d[7];
      if (d[7] && d[6:5] == 2'b00 && !d[2]) begin
        d_a = d[4]; d_b = d[1]; d_ch = d[3]; d_cl = d[0];
      end
    end else begin
      m_lat[a*8 +: 8] = d;
    end
    @(negedge clk);
    bus_wr = 1'b0;
    #1;
  endtask

  task automatic rd(input string req, input logic [1:0] a, input logic [23:0] pins);
    @(negedge clk);
    bus_addr = a; pin_in = pins;
    #1;
    chk(req, "bus_rdata", 32'(bus_rdata), 32'(exp_rd(a, pins)));
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1 reset state
    check_outs("R1");
    chk("R1", "xcvr_dir reset", 32'(xcvr_dir), 32'h0);
    rd("R9", 2'd3, 24'h0);
    chk("R9", "ctrl reset value", 32'(bus_rdata), 32'h1B);
    // R8 inputs read live
    rd("R8", 2'd0, 24'h3C5AA5);
    rd("R8", 2'd1, 24'h3C5AA5);
    rd("R8", 2'd2, 24'h3C5AA5);
    // R6 latch written while input, not driven
    wr(2'd0, 8'hA5);
    check_outs("R6");
    chk("R6", "no drive while input", 32'(pin_oe), 32'h0);
    // R10 preset sequence
    wr(2'd3, 8'h80);
    check_outs("R2");
    chk("R3", "tristated", 32'(pin_oe), 32'h0);
    wr(2'd1, 8'h96);
    wr(2'd2, 8'hE1);
    check_outs("R6");
    wr(2'd3, 8'h00);
    check_outs("R4");
    chk("R10", "all driven", 32'(pin_oe), 32'hFFFFFF);
    chk("R10", "preset data", 32'(pin_out), 32'hE196A5);
    rd("R8", 2'd1, 24'h000000);
    // R5 bad mode bits
    wr(2'd3, 8'hBB);
    check_outs("R5");
    chk("R5", "dirs kept", 32'(xcvr_dir), 32'hF);
    wr(2'd3, 8'h84);
    check_outs("R5");
    // mixed: A out, B in, C hi in, C lo out
    wr(2'd3, 8'h8A);
    wr(2'd3, 8'h0A);
    check_outs("R2");
    chk("R2", "mixed dirs", 32'(xcvr_dir), 32'h5);
    rd("R8", 2'd2, 24'hFFFFFF);
    rd("R9", 2'd3, 24'h0);
    // random mix
    for (int n = 0; n < 400; n++) begin
      int op = $urandom_range(9, 0);
      logic [7:0] d = 8'($urandom);
      if (op < 3) begin
        if ($urandom_range(3, 0) != 0) d = d & 8'h9B;
        wr(2'd3, d);
        check_outs("R2");
      end else if (op < 6) begin
        wr(2'($urandom_range(2, 0)), d);
        check_outs("R6");
      end else begin
        rd("R8", 2'($urandom_range(3, 0)), 24'($urandom));
      end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule